// File: doc/BRIEF.md
# Seven-Pin Multiplexed I/O Port with Alternate Functions

This block is a seven-pin general-purpose I/O port on a simple register bus. Each pin is either a plain port pin or is handed to an alternate function. As a plain pin it drives its output-latch bit or reads back the pad. In alternate use it carries a strobe, an address bit or a control line for an external memory controller. The memory controller and the pad cells are outside the block. The block only decides, pin by pin, what each pad drives, whether the pad is driven, and where an incoming pad level is routed.

Software programs the port through four registers. The data register is a latch when written and shows the pad levels when read. The direction and function-select registers are write-only. The standby drive register can be read and written. While the standby input is high, any pin whose drive bit is 0 has its output enable and its input path shut off.

The register bus is not a stream. It takes one access per cycle, has no back-pressure and no ready signal, and returns read data one cycle after the request. The pad and alternate-function pins are plain level signals.

Top module: `gpio7_port`

## Requirements
- R1: After reset the direction and function bits are all 0 and the output latch bits are all 1. So no pin is driven, and setting every direction bit with no latch write drives 1 on every pin.
- R2: With function bit i at 0, pin i is driven exactly when direction bit i is 1, and pin_out[i] equals latch bit i.
- R3: A read of address 0 returns the pad levels pin_in[6:0], sampled at the request edge, on bus_rdata after that edge. A write to address 0 loads the output latch.
- R4: Address 1 (direction, bit i = pin i, 1 = output) and address 2 (function, bit i = pin i, 1 = alternate) are write-only, and reads of them return 0.
- R5: Address 3 is the standby drive register. It resets to 7'h7F and reads back what was written.
- R6: Pin 1 with function and direction both 1 drives nand_re_n when latch bit 1 is 0, and wr_lo_n when latch bit 1 is 1.
- R7: Pin 2 with function and direction both 1 drives nand_we_n when latch bit 2 is 0, and wr_hi_n when latch bit 2 is 1.
- R8: With function and direction both 1, pin 0 drives rd_n, pin 3 drives ext_addr[0] and pin 4 drives ext_addr[1].
- R9: Pin 5 with function 1 and direction 1 drives rw_out. With function 1 and direction 0 it is undriven and its pad level appears on alt_ready.
- R10: Pin 6 with function 1 and direction 0 is undriven and its pad level appears on alt_wait_n.
- R11: Reserved combinations leave the pin undriven. These are function 1 with direction 0 on pins 0 to 4, and function 1 with direction 1 on pin 6.
- R12: While standby is 1, every pin whose drive bit is 0 is undriven, reads as 0 at address 0, and feeds no alternate input.
- R13: When a pin is not routed to alt_wait_n or alt_ready, that output holds its idle value of 1.
- R14: Writing the latch bits to 0, then the function bits to 1, then the direction bits to 1 keeps pins 1 and 2 undriven until the direction write. After that write they carry the NAND strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 function, 3 drive |
| bus_wdata | input | 7 | Write data, bit i = pin i |
| bus_rdata | output | 7 | Read data, valid the cycle after a read request |
| standby | input | 1 | Standby mode indication |
| pin_in | input | 7 | Pad input levels |
| pin_out | output | 7 | Pad output values |
| pin_oe | output | 7 | Pad output enables |
| rd_n | input | 1 | Read strobe source for pin 0 |
| nand_re_n | input | 1 | NAND read strobe source for pin 1 |
| wr_lo_n | input | 1 | Low-byte write strobe source for pin 1 |
| nand_we_n | input | 1 | NAND write strobe source for pin 2 |
| wr_hi_n | input | 1 | Upper-byte write strobe source for pin 2 |
| ext_addr | input | 2 | Extended address bits for pins 3 and 4 |
| rw_out | input | 1 | Read/write line source for pin 5 |
| alt_ready | output | 1 | Ready/busy level routed from pin 5, idle 1 |
| alt_wait_n | output | 1 | Wait level routed from pin 6, idle 1 |

## Verification
A register write takes effect at the clock edge that accepts it. The pin outputs, the output enables and the routed alternate inputs are combinational from register state, standby and the pads. So the bench checks them at the falling edge after the write, and again a short delay after any pad or source input changes with no clock in between. Read data is registered and is due at the edge after the request. The bench holds the request through exactly one rising edge and samples bus_rdata at the falling edge that follows.

// File: rtl/gpio7_pkg.sv
package gpio7_pkg;
  localparam int NPIN   = 7;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FUNC  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DRIVE = 2'd3;

  // pins 0..5 have an alternate output
  function automatic bit alt_out_ok(input int idx);
    return idx <= 5;
  endfunction

  // pins 1 and 2 pick between two strobes using the latch bit
  function automatic bit latch_pick(input int idx);
    return (idx == 1) || (idx == 2);
  endfunction
endpackage

// File: rtl/gpio7_regs.sv
module gpio7_regs
  import gpio7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   pad_seen,
  output logic [NPIN-1:0]   latch_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   func_q,
  output logic [NPIN-1:0]   drive_q,
  output logic [NPIN-1:0]   rdata
);
  logic [NPIN-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (addr)
      ADDR_DATA:  rd_next = pad_seen;
      ADDR_DRIVE: rd_next = drive_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '0;
      func_q  <= '0;
      drive_q <= '1;
      rdata   <= '0;
    end else if (sel) begin
      if (wr) begin
        unique case (addr)
          ADDR_DATA:  latch_q <= wdata;
          ADDR_DIR:   dir_q   <= wdata;
          ADDR_FUNC:  func_q  <= wdata;
          ADDR_DRIVE: drive_q <= wdata;
          default: ;
        endcase
      end else begin
        rdata <= rd_next;
      end
    end
  end
endmodule

// File: rtl/gpio7_pin.sv
module gpio7_pin #(
  parameter bit HAS_ALT_OUT = 1'b0,
  parameter bit LATCH_PICK  = 1'b0
) (
  input  logic dir_i,
  input  logic func_i,
  input  logic latch_i,
  input  logic alt_a_i,
  input  logic alt_b_i,
  input  logic pad_i,
  input  logic block_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic pad_seen_o
);
  logic alt_drive;
  logic alt_val;

  always_comb begin
    alt_drive  = func_i & dir_i & HAS_ALT_OUT;
    alt_val    = (LATCH_PICK && latch_i) ? alt_b_i : alt_a_i;
    pad_o      = func_i ? (alt_drive ? alt_val : 1'b0) : latch_i;
    pad_oe_o   = (func_i ? alt_drive : dir_i) & ~block_i;
    pad_seen_o = pad_i & ~block_i;
  end
endmodule

// File: rtl/gpio7_port.sv
module gpio7_port
  import gpio7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic              standby,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  input  logic              rd_n,
  input  logic              nand_re_n,
  input  logic              wr_lo_n,
  input  logic              nand_we_n,
  input  logic              wr_hi_n,
  input  logic [1:0]        ext_addr,
  input  logic              rw_out,
  output logic              alt_ready,
  output logic              alt_wait_n
);
  logic [NPIN-1:0] latch_q, dir_q, func_q, drive_q;
  logic [NPIN-1:0] blocked, pad_seen, alt_a, alt_b;

  assign blocked = {NPIN{standby}} & ~drive_q;
  assign alt_a   = {1'b1, rw_out, ext_addr[1], ext_addr[0], nand_we_n, nand_re_n, rd_n};
  assign alt_b   = {4'hF, wr_hi_n, wr_lo_n, 1'b1};

  gpio7_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pad_seen (pad_seen),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .func_q   (func_q),
    .drive_q  (drive_q),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio7_pin #(
      .HAS_ALT_OUT (alt_out_ok(i)),
      .LATCH_PICK  (latch_pick(i))
    ) u_pin (
      .dir_i      (dir_q[i]),
      .func_i     (func_q[i]),
      .latch_i    (latch_q[i]),
      .alt_a_i    (alt_a[i]),
      .alt_b_i    (alt_b[i]),
      .pad_i      (pin_in[i]),
      .block_i    (blocked[i]),
      .pad_o      (pin_out[i]),
      .pad_oe_o   (pin_oe[i]),
      .pad_seen_o (pad_seen[i])
    );
  end

  assign alt_ready  = (func_q[5] & ~dir_q[5] & ~blocked[5]) ? pin_in[5] : 1'b1;
  assign alt_wait_n = (func_q[6] & ~dir_q[6] & ~blocked[6]) ? pin_in[6] : 1'b1;
endmodule

// File: rtl/gpio7_port_chk.sv
module gpio7_port_chk
  import gpio7_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_rdata,
  input logic              standby,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              nand_re_n,
  input logic              alt_wait_n,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   func_q,
  input logic [NPIN-1:0]   latch_q,
  input logic [NPIN-1:0]   drive_q
);
  AST_PLAIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |-> (((pin_oe ^ dir_q) & ~func_q) == '0)); // R2

  AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_DATA && !standby) |=> (bus_rdata == $past(pin_in))); // R3

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == ADDR_DIR || bus_addr == ADDR_FUNC)) |=> (bus_rdata == '0)); // R4

  AST_NAND_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q[1] && dir_q[1] && !latch_q[1] && !standby) |-> (pin_oe[1] && pin_out[1] == nand_re_n)); // R6

  AST_WAIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q[6] && !dir_q[6] && !standby) |-> (alt_wait_n == pin_in[6])); // R10

  AST_PIN6_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q[6] && dir_q[6]) |-> !pin_oe[6]); // R11

  AST_STANDBY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ((pin_oe & ~drive_q) == '0)); // R12
endmodule

bind gpio7_port gpio7_port_chk u_chk (.*);

// File: tb/gpio7_port_bench.sv
module gpio7_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [6:0] bus_wdata = '0;
  logic [6:0] bus_rdata;
  logic       standby = 1'b0;
  logic [6:0] pin_in = '0;
  logic [6:0] pin_out, pin_oe;
  logic       rd_n = 1'b1, nand_re_n = 1'b1, wr_lo_n = 1'b1, nand_we_n = 1'b1, wr_hi_n = 1'b1;
  logic [1:0] ext_addr = '0;
  logic       rw_out = 1'b1;
  logic       alt_ready, alt_wait_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio7_port u_gpio7_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .standby(standby), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rd_n(rd_n), .nand_re_n(nand_re_n),
    .wr_lo_n(wr_lo_n), .nand_we_n(nand_we_n), .wr_hi_n(wr_hi_n), .ext_addr(ext_addr),
    .rw_out(rw_out), .alt_ready(alt_ready), .alt_wait_n(alt_wait_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [6:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [6:0] v;
    chk("R1 oe after reset", pin_oe, 7'h00);
    rd_reg(2'd3, v); chk("R5 drive reset", v, 7'h7F);
    rd_reg(2'd1, v); chk("R4 dir read zero", v, 7'h00);
    wr_reg(2'd1, 7'h7F);
    chk("R1 latch reset ones oe", pin_oe, 7'h7F);
    chk("R1 latch reset ones out", pin_out, 7'h7F);
    rd_reg(2'd1, v); chk("R4 dir read zero after write", v, 7'h00);
    wr_reg(2'd1, 7'h00);
  endtask

  task automatic t_plain();
    wr_reg(2'd0, 7'h55);
    wr_reg(2'd1, 7'h0F);
    chk("R2 plain oe", pin_oe, 7'h0F);
    chk("R2 plain out", pin_out, 7'h55);
    wr_reg(2'd0, 7'h2A);
    chk("R2 plain out new latch", pin_out, 7'h2A);
    wr_reg(2'd1, 7'h00);
  endtask

  task automatic t_read();
    logic [6:0] v;
    pin_in = 7'h2A; rd_reg(2'd0, v); chk("R3 pad read 2A", v, 7'h2A);
    pin_in = 7'h55; rd_reg(2'd0, v); chk("R3 pad read 55", v, 7'h55);
    wr_reg(2'd2, 7'h11);
    rd_reg(2'd2, v); chk("R4 func read zero", v, 7'h00);
    wr_reg(2'd2, 7'h00);
  endtask

  task automatic t_drive();
    logic [6:0] v;
    wr_reg(2'd3, 7'h13); rd_reg(2'd3, v); chk("R5 drive readback", v, 7'h13);
    wr_reg(2'd3, 7'h7F);
  endtask

  task automatic t_strobes();
    nand_re_n = 1'b1; nand_we_n = 1'b0; wr_lo_n = 1'b0; wr_hi_n = 1'b1;
    wr_reg(2'd0, 7'h00);
    chk("R14 step1 undriven", pin_oe[2:1], 2'b00);
    wr_reg(2'd2, 7'h06);
    chk("R14 step2 undriven", pin_oe[2:1], 2'b00);
    wr_reg(2'd1, 7'h06);
    chk("R14 step3 driven", pin_oe[2:1], 2'b11);
    chk("R6 nand re", pin_out[1], 1'b1);
    chk("R7 nand we", pin_out[2], 1'b0);
    nand_re_n = 1'b0; nand_we_n = 1'b1; #1;
    chk("R6 nand re toggle", pin_out[1], 1'b0);
    chk("R7 nand we toggle", pin_out[2], 1'b1);
    wr_reg(2'd0, 7'h06);
    chk("R6 low write strobe", pin_out[1], 1'b0);
    chk("R7 high write strobe", pin_out[2], 1'b1);
    wr_lo_n = 1'b1; wr_hi_n = 1'b0; #1;
    chk("R6 low write toggle", pin_out[1], 1'b1);
    chk("R7 high write toggle", pin_out[2], 1'b0);
    wr_reg(2'd1, 7'h00); wr_reg(2'd2, 7'h00);
  endtask

  task automatic t_addr();
    rd_n = 1'b0; ext_addr = 2'b10;
    wr_reg(2'd2, 7'h19); wr_reg(2'd1, 7'h19);
    chk("R8 oe", pin_oe, 7'h19);
    chk("R8 rd and addr", {pin_out[4], pin_out[3], pin_out[0]}, 3'b100);
    rd_n = 1'b1; ext_addr = 2'b01; #1;
    chk("R8 rd and addr toggle", {pin_out[4], pin_out[3], pin_out[0]}, 3'b011);
    wr_reg(2'd1, 7'h00);
    chk("R11 input alt pins 0 3 4 undriven", pin_oe, 7'h00);
    wr_reg(2'd2, 7'h00);
  endtask

  task automatic t_pin5();
    rw_out = 1'b0;
    wr_reg(2'd2, 7'h20); wr_reg(2'd1, 7'h20);
    chk("R9 rw oe", pin_oe[5], 1'b1);
    chk("R9 rw out", pin_out[5], 1'b0);
    chk("R13 ready idle in output alt", alt_ready, 1'b1);
    wr_reg(2'd1, 7'h00);
    pin_in = 7'h00; #1;
    chk("R9 ready routed low", alt_ready, 1'b0);
    chk("R9 ready input undriven", pin_oe[5], 1'b0);
    pin_in = 7'h20; #1;
    chk("R9 ready routed high", alt_ready, 1'b1);
    wr_reg(2'd2, 7'h00);
    pin_in = 7'h00; #1;
    chk("R13 ready idle plain", alt_ready, 1'b1);
  endtask

  task automatic t_pin6();
    wr_reg(2'd2, 7'h40);
    pin_in = 7'h00; #1;
    chk("R10 wait routed low", alt_wait_n, 1'b0);
    chk("R10 wait undriven", pin_oe[6], 1'b0);
    wr_reg(2'd1, 7'h40);
    chk("R11 pin6 output alt undriven", pin_oe[6], 1'b0);
    chk("R13 wait idle", alt_wait_n, 1'b1);
    wr_reg(2'd1, 7'h00);
    wr_reg(2'd2, 7'h1F);
    chk("R11 pins 0-4 input alt undriven", pin_oe, 7'h00);
    wr_reg(2'd2, 7'h00);
  endtask

  task automatic t_standby();
    logic [6:0] v;
    wr_reg(2'd3, 7'h30);
    wr_reg(2'd1, 7'h7F);
    standby = 1'b1; #1;
    chk("R12 standby oe gated", pin_oe, 7'h30);
    pin_in = 7'h7F;
    rd_reg(2'd0, v); chk("R12 standby read gated", v, 7'h30);
    standby = 1'b0; #1;
    chk("R12 standby released", pin_oe, 7'h7F);
    wr_reg(2'd1, 7'h00);
    wr_reg(2'd2, 7'h40);
    pin_in = 7'h00; standby = 1'b1; #1;
    chk("R12 wait input gated", alt_wait_n, 1'b1);
    standby = 1'b0; #1;
    chk("R12 wait input ungated", alt_wait_n, 1'b0);
    wr_reg(2'd2, 7'h00); wr_reg(2'd3, 7'h7F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_read();
    t_drive();
    t_strobes();
    t_addr();
    t_pin5();
    t_pin6();
    t_standby();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule